// File: doc/BRIEF.md
# Oversampled UART Receiver with Selectable Parity and Error Routing

This block receives asynchronous serial characters on a single input line. It counts a tick strobe that runs at sixteen times the baud rate. It finds the falling edge of a start bit, checks that the line is still low half a bit later, and then samples every later bit in the middle of its cell. A character holds seven or eight data bits, least significant bit first. An optional parity bit follows the data, and then a stop bit. When a character ends, the block stores the byte, updates three error flags (parity, framing, overrun) and gives a one-cycle interrupt pulse.

Parity has four settings: no parity bit, a parity bit that is received but never judged, odd parity and even parity. A routing select decides where an errored character is reported. It goes either to a dedicated error pulse or to the normal completion pulse, and never to both. A read strobe from the consumer acknowledges each character. A character that completes while the previous one is still unacknowledged raises an overrun.

The block receives only while it is powered and enabled. The enable must be raised after the power bit. Dropping either one puts the whole receive path back to its reset state on the next clock.

Top module: `uart_rx_route`

## Requirements
- R1: With `len8`=1 a character carries 8 data bits. With `len8`=0 it carries 7, and `rx_data[7]` reads 0. Data bits arrive least significant bit first.
- R2: With `par_mode`=2'b00 no parity bit is expected, and the stop bit follows the last data bit directly.
- R3: With `par_mode`=2'b01 one parity bit is received but not judged. `perr` stays 0, and parity never causes an error pulse.
- R4: With `par_mode`=2'b10 the data bits plus the parity bit must hold an odd number of ones. With 2'b11 they must hold an even number. A mismatch sets `perr` for that character.
- R5: Only the first stop bit is sampled. If it samples low, `ferr` is set for that character, and the byte is still stored.
- R6: If a character completes while the previous one has not been acknowledged by `rd_ack`, `oerr` is set for it. `rd_ack` clears the pending state.
- R7: A character with no error gives exactly one `done_irq` pulse. With `err_to_done`=0, an errored character gives exactly one `err_irq` pulse and no `done_irq`. With `err_to_done`=1, it gives exactly one `done_irq` pulse and no `err_irq`.
- R8: Taking `rx_en` low clears `rx_data`, all flags and any partial character on the next clock. After it returns high, the next full character is received correctly.
- R9: If `rx_en` rises while `pwr_on` is 0, no character is received after power comes on until `rx_en` has been low for at least one cycle and rises again.
- R10: A low pulse that is high again at the mid-bit sample (8 ticks after the falling edge) is rejected and produces no pulse.
- R11: After reset `rx_data`, `perr`, `ferr`, `oerr`, `done_irq` and `err_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Receiver power bit |
| rx_en | input | 1 | Receive enable; low resets the receive path |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_mode | input | 2 | 00 none, 01 received unjudged, 10 odd, 11 even |
| err_to_done | input | 1 | 0: errors to `err_irq`, 1: errors to `done_irq` |
| tick | input | 1 | One-cycle strobe at 16x the baud rate |
| rxd | input | 1 | Serial input, idle high |
| rd_ack | input | 1 | Consumer has read the current byte |
| rx_data | output | 8 | Last received byte |
| perr | output | 1 | Parity error of the last character |
| ferr | output | 1 | Framing error of the last character |
| oerr | output | 1 | Overrun error of the last character |
| done_irq | output | 1 | One-cycle reception-complete pulse |
| err_irq | output | 1 | One-cycle reception-error pulse |

## Verification
Every result appears a fixed number of cycles after the stop-bit mid sample. The line first passes a two-flop synchronizer, the decision is taken on a tick, and one more register stage then updates the byte, the flags and the pulse together. That puts the result about 8 ticks plus 4 cycles after the stop bit starts. The bench holds the line idle for a full bit after every stop bit before it samples, so every result has settled by then. It counts interrupt pulses on each clock edge over the whole character instead of trying to catch one cycle. Effects of the enable are checked on the second falling clock edge after the enable changes. By then the one register stage that applies the reset has updated.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b1;
          else        pipe_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= 1'b1;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          len8,
  input  logic          par_on,
  output logic [DW-1:0] data,
  output logic          pbit,
  output logic          stop_ok,
  output logic          done
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bitn_q, bitn_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          par_q, par_d;
  logic          stop_q, stop_d;
  logic          done_q, done_d;
  logic [BW-1:0] last_bit;

  assign last_bit = len8 ? BW'(DW - 1) : BW'(DW - 2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    par_d   = par_q;
    stop_d  = stop_q;
    done_d  = 1'b0;
    if (!active) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      bitn_d  = '0;
      sh_d    = '0;
      par_d   = 1'b0;
      stop_d  = 1'b1;
    end else if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rxd_s) state_d = RX_START;
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d   = '0;
            bitn_d  = '0;
            state_d = rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            sh_d  = {rxd_s, sh_q[DW-1:1]};
            if (bitn_q == last_bit) state_d = par_on ? RX_PAR : RX_STOP;
            else                    bitn_d  = bitn_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            par_d   = rxd_s;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            stop_d  = rxd_s;
            done_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      stop_q  <= stop_d;
      done_q  <= done_d;
    end
  end

  assign data    = len8 ? sh_q : {1'b0, sh_q[DW-1:1]};
  assign pbit    = par_q;
  assign stop_ok = stop_q;
  assign done    = done_q;
endmodule

// File: rtl/uart_rx_report.sv
module uart_rx_report #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          done,
  input  logic [DW-1:0] data,
  input  logic          pbit,
  input  logic          stop_ok,
  input  logic [1:0]    par_mode,
  input  logic          err_to_done,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          perr,
  output logic          ferr,
  output logic          oerr,
  output logic          done_irq,
  output logic          err_irq
);
  logic [DW-1:0] data_q, data_d;
  logic          perr_q, perr_d, ferr_q, ferr_d, oerr_q, oerr_d;
  logic          pend_q, pend_d, dirq_q, dirq_d, eirq_q, eirq_d;
  logic          p_bad, any_err;

  assign p_bad   = par_mode[1] & ((^{data, pbit}) == par_mode[0]);
  assign any_err = p_bad | ~stop_ok | (pend_q & ~rd_ack);

  always_comb begin
    data_d = data_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    oerr_d = oerr_q;
    pend_d = pend_q;
    dirq_d = 1'b0;
    eirq_d = 1'b0;
    if (!active) begin
      data_d = '0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
      oerr_d = 1'b0;
      pend_d = 1'b0;
    end else if (done) begin
      data_d = data;
      perr_d = p_bad;
      ferr_d = ~stop_ok;
      oerr_d = pend_q & ~rd_ack;
      pend_d = 1'b1;
      dirq_d = ~any_err | err_to_done;
      eirq_d = any_err & ~err_to_done;
    end else if (rd_ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
      pend_q <= 1'b0;
      dirq_q <= 1'b0;
      eirq_q <= 1'b0;
    end else begin
      data_q <= data_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      oerr_q <= oerr_d;
      pend_q <= pend_d;
      dirq_q <= dirq_d;
      eirq_q <= eirq_d;
    end
  end

  assign rx_data  = data_q;
  assign perr     = perr_q;
  assign ferr     = ferr_q;
  assign oerr     = oerr_q;
  assign done_irq = dirq_q;
  assign err_irq  = eirq_q;
endmodule

// File: rtl/uart_rx_route.sv
module uart_rx_route #(
  parameter int OSR      = 16,
  parameter int DW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on,
  input  logic          rx_en,
  input  logic          len8,
  input  logic [1:0]    par_mode,
  input  logic          err_to_done,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rd_ack,
  output logic [DW-1:0] rx_data,
  output logic          perr,
  output logic          ferr,
  output logic          oerr,
  output logic          done_irq,
  output logic          err_irq
);
  logic          en_q, armed_q, armed_d, active;
  logic          rxd_s, c_done, c_pbit, c_stop;
  logic [DW-1:0] c_data;

  // arming: enable must rise while power is already on
  assign armed_d = pwr_on & rx_en & (armed_q | ~en_q);
  assign active  = armed_q & pwr_on & rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= rx_en;
      armed_q <= armed_d;
    end
  end

  uart_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_rx_core #(.OSR(OSR), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .rxd_s(rxd_s),
    .len8(len8), .par_on(par_mode != 2'b00), .data(c_data), .pbit(c_pbit),
    .stop_ok(c_stop), .done(c_done)
  );

  uart_rx_report #(.DW(DW)) u_report (
    .clk(clk), .rst_n(rst_n), .active(active), .done(c_done), .data(c_data),
    .pbit(c_pbit), .stop_ok(c_stop), .par_mode(par_mode),
    .err_to_done(err_to_done), .rd_ack(rd_ack), .rx_data(rx_data),
    .perr(perr), .ferr(ferr), .oerr(oerr), .done_irq(done_irq),
    .err_irq(err_irq)
  );
endmodule

// File: rtl/uart_rx_route_chk.sv
module uart_rx_route_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          len8,
  input logic [1:0]    par_mode,
  input logic          err_to_done,
  input logic [DW-1:0] rx_data,
  input logic          perr,
  input logic          ferr,
  input logic          oerr,
  input logic          done_irq,
  input logic          err_irq
);
  // R7: never both pulses
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_irq && err_irq));

  // R7: error pulse only for an errored character under dedicated routing
  a_r7_err_route: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (perr || ferr || oerr) && !err_to_done);

  // R7: completion pulse under dedicated routing means a clean character
  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !err_to_done) |-> !(perr || ferr || oerr));

  // R3: parity never judged outside odd/even modes
  a_r3_no_judge: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_irq || err_irq) && !par_mode[1]) |-> !perr);

  // R1: seven-bit characters leave the top data bit clear
  a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_irq || err_irq) && !len8) |-> !rx_data[DW-1]);

  // R8: disabling silences pulses and clears flags on the next clock
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !done_irq && !err_irq && !perr && !ferr && !oerr);
endmodule

bind uart_rx_route uart_rx_route_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_uart_rx_route.sv
module test_uart_rx_route;
  localparam int BITC = 32;  // 16 ticks x 2 cycles per tick

  logic       clk, rst_n, pwr_on, rx_en, len8, err_to_done, tick, rxd, rd_ack;
  logic [1:0] par_mode;
  logic [7:0] rx_data;
  logic       perr, ferr, oerr, done_irq, err_irq;

  int n_chk = 0, n_err = 0, n_done = 0, n_eirq = 0, cyc = 0;
  bit pend = 0, finished = 0;

  uart_rx_route i_uart_rx_route (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .rx_en(rx_en), .len8(len8),
    .par_mode(par_mode), .err_to_done(err_to_done), .tick(tick), .rxd(rxd),
    .rd_ack(rd_ack), .rx_data(rx_data), .perr(perr), .ferr(ferr),
    .oerr(oerr), .done_irq(done_irq), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_irq) n_done <= n_done + 1;
    if (err_irq)  n_eirq <= n_eirq + 1;
  end

  always @(posedge clk)
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic p;
    bit_out(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) bit_out(d[i]);
    if (par_mode != 2'b00) begin
      p = (par_mode == 2'b01) ? 1'b0 :
          (par_mode == 2'b10) ? ~^(len8 ? d : {1'b0, d[6:0]}) : ^(len8 ? d : {1'b0, d[6:0]});
      bit_out(bad_par ? ~p : p);
    end
    bit_out(bad_stop ? 1'b0 : 1'b1);
    bit_out(1'b1);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    pend = 0;
  endtask

  // send one character and compare byte, flags and pulse counts
  task automatic frame(input string tag, input logic [7:0] d, input bit bp, input bit bs, input bit ack);
    int d0, e0;
    logic [7:0] ed;
    logic ep, ef, eo, er;
    d0 = n_done; e0 = n_eirq;
    send(d, bp, bs);
    ed = len8 ? d : {1'b0, d[6:0]};
    ep = bp && par_mode[1];
    ef = bs;
    eo = pend;
    er = ep | ef | eo;
    check(tag, {rx_data, 1'b0, perr, ferr, oerr, 2'(n_done - d0), 2'(n_eirq - e0)},
               {ed, 1'b0, ep, ef, eo, (err_to_done || !er) ? 2'd1 : 2'd0,
                (!err_to_done && er) ? 2'd1 : 2'd0});
    pend = 1;
    if (ack) pulse_ack();
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'hA5;
      1: return 8'h3C;
      2: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    int d0, e0;
    rst_n = 1'b0; pwr_on = 1'b0; rx_en = 1'b0; len8 = 1'b1; par_mode = 2'b00;
    err_to_done = 1'b0; rxd = 1'b1; rd_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset", {rx_data, 3'b0, perr, ferr, oerr, done_irq, err_irq}, 16'h0);

    pwr_on = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R5 R7 sweep over length, parity mode, routing and data
    for (int l = 0; l < 2; l++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 2; r++)
          for (int i = 0; i < 4; i++) begin
            len8 = l[0]; par_mode = m[1:0]; err_to_done = r[0];
            @(negedge clk);
            frame($sformatf("R1 R2 R3 R4 R5 R7 len8=%0d mode=%0d route=%0d i=%0d", l, m, r, i),
                  pick(i) ^ 8'(m * 17), i == 1, i == 2, 1'b1);
          end

    // R6 overrun under both routings
    len8 = 1'b1; par_mode = 2'b00;
    for (int r = 0; r < 2; r++) begin
      err_to_done = r[0];
      frame("R6 first", 8'h11, 0, 0, 1'b0);
      frame("R6 overrun R7", 8'h22, 0, 0, 1'b0);
      pulse_ack();
      frame("R6 after ack", 8'h33, 0, 0, 1'b1);
    end

    // R10 short low glitch rejected
    err_to_done = 1'b0;
    d0 = n_done; e0 = n_eirq;
    bit_out(1'b1);
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (3 * BITC) @(negedge clk);
    check("R10 glitch", 16'(n_done - d0 + n_eirq - e0), 16'd0);
    frame("R10 after glitch", 8'h5A, 0, 0, 1'b1);

    // R8 disable clears flags and byte
    frame("R8 setup", 8'hC3, 0, 1, 1'b1);
    rx_en = 1'b0; pend = 0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    check("R8 cleared", {rx_data, 5'b0, perr, ferr, oerr}, 16'h0);

    // R8 disable mid-character, then a clean character
    d0 = n_done; e0 = n_eirq;
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    rxd = 1'b1; repeat (2 * BITC) @(negedge clk);
    check("R8 partial dropped", 16'(n_done - d0 + n_eirq - e0), 16'd0);
    frame("R8 after reenable", 8'h96, 0, 0, 1'b1);

    // R9 enable before power is not accepted
    pwr_on = 1'b0; rx_en = 1'b0; pend = 0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    pwr_on = 1'b1;
    repeat (4) @(negedge clk);
    d0 = n_done; e0 = n_eirq;
    send(8'h69, 0, 0);
    check("R9 wrong order", 16'(n_done - d0 + n_eirq - e0), 16'd0);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    frame("R9 correct order", 8'h69, 0, 0, 1'b1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule